// File: doc/BRIEF.md
# Predicated Gather Prefetch Address Sequencer

This block turns one gather prefetch operation into a stream of prefetch requests. On a start pulse it captures a vector of base addresses, a governing predicate holding one bit per vector byte, a lane-width select (32-bit or 64-bit lanes), a 5-bit immediate and a 4-bit prefetch operation code. It then walks the lanes from lane 0 upward. For each lane whose predicate bit is set, it emits one request on a valid/ready port. Lanes whose predicate bit is clear are passed over and produce nothing.

Each request carries a 64-bit address and three decoded hint fields. The address is the zero-extended lane value plus the immediate scaled by eight. The hint fields are a write/read type, a cache level and a streaming (non-temporal) flag. A busy level covers the whole operation, and a one-cycle done pulse closes it. An operation with no active lane finishes without sending any request, and the base vector is left unsampled in that case.

Top module: `gather_prefetch_seq`

## Requirements
- R1: After reset, `busy`, `done` and `reqValid` are all low.
- R2: Each request address equals the zero-extended lane value plus `imm5` times 8. The offset is therefore a multiple of 8 from 0 to 248. A 32-bit lane never carries into a wrapped result: for example, 0xFFFFFFFF plus 248 gives 0x1_000000F7.
- R3: With `elemSel64`=0 there are VLEN/32 lanes. Lane e is `baseVec[32e+31:32e]` and is active when `predMask[4e]` is 1. Other predicate bits are ignored.
- R4: With `elemSel64`=1 there are VLEN/64 lanes. Lane e is `baseVec[64e+63:64e]` and is active when `predMask[8e]` is 1. Other predicate bits are ignored.
- R5: Requests are issued only for active lanes, exactly one per active lane, in ascending lane order. No request appears outside an operation.
- R6: `reqWrite` equals `hintOp[3]` (1 means write prefetch, 0 means read prefetch). `reqLevel` equals `hintOp[2:1]`. `reqStream` equals `hintOp[0]`.
- R7: While `reqValid` is high and `reqReady` is low, the request stays valid and its address and hint fields hold steady.
- R8: `busy` rises in the cycle after start is accepted and stays high through the cycle in which `done` is high. `done` lasts exactly one cycle and comes after the last lane has been handled. `busy` is low in the following cycle.
- R9: When no lane is active, the operation issues no request and still ends with a `done` pulse.
- R10: `start` is ignored while `busy` is high, including in the cycle in which `done` is high. Operand inputs are captured only when start is accepted, so changing them later has no effect.
- R11: For 64-bit lanes, the address sum wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| elemSel64 | input | 1 | 1 selects 64-bit lanes, 0 selects 32-bit lanes |
| baseVec | input | VLEN | Vector of lane base addresses |
| predMask | input | VLEN/8 | Governing predicate, one bit per byte |
| imm5 | input | 5 | Immediate, scaled by 8 to form the byte offset |
| hintOp | input | 4 | Prefetch operation code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| reqValid | output | 1 | Request valid |
| reqReady | input | 1 | Request accepted by consumer |
| reqAddr | output | 64 | Prefetch address |
| reqWrite | output | 1 | Write prefetch when 1, read prefetch when 0 |
| reqLevel | output | 2 | Target cache level |
| reqStream | output | 1 | Streaming hint |

## Verification
Two events can fall in the same cycle: the done pulse that closes one operation, and a new start request that arrives while the block is still counted as busy. The bench provokes this by raising `start` in exactly the cycle where `done` is high, with an all-active operand set that would produce requests if it were accepted. The collision is judged correct when no request follows and `busy` stays low. The same judgement is applied to a start raised in the middle of a walk that is being slowed by random ready back-pressure.

// File: rtl/gps_pkg.sv
package gps_pkg;
  typedef struct packed {
    logic load;   // capture operands, reset lane index
    logic step;   // move to next lane
  } gpsStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FIN  = 2'd2
  } gpsState_t;
endpackage

// File: rtl/gps_ctrl.sv
module gps_ctrl
  import gps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       anyActive,
  input  logic       laneActive,
  input  logic       lastLane,
  input  logic       reqReady,
  output gpsStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       reqValid
);
  gpsState_t state, stateNext;
  logic      laneHandled;

  assign laneHandled = !laneActive || reqReady;

  always_comb begin
    stateNext   = state;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    reqValid    = 1'b0;
    done        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = anyActive ? ST_WALK : ST_FIN;
        end
      end
      ST_WALK: begin
        reqValid = laneActive;
        if (laneHandled) begin
          if (lastLane) stateNext = ST_FIN;
          else strobe.step = 1'b1;
        end
      end
      ST_FIN: begin
        done      = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/gps_dp.sv
module gps_dp
  import gps_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpsStrobe_t           strobe,
  input  logic                 elemSel64,
  input  logic [VLEN-1:0]      baseVec,
  input  logic [VLEN/8-1:0]    predMask,
  input  logic [4:0]           imm5,
  input  logic [3:0]           hintOp,
  output logic                 anyActive,
  output logic                 laneActive,
  output logic                 lastLane,
  output logic [63:0]          reqAddr,
  output logic                 reqWrite,
  output logic [1:0]           reqLevel,
  output logic                 reqStream
);
  localparam int PRED_W  = VLEN / 8;
  localparam int LANES32 = VLEN / 32;
  localparam int LANES64 = VLEN / 64;
  localparam int IDX_W   = $clog2(LANES32);
  localparam int IDX64_W = IDX_W - 1;

  logic [VLEN-1:0]   baseReg;
  logic [PRED_W-1:0] maskReg;
  logic              is64Reg;
  logic [7:0]        offReg;
  logic [3:0]        hintReg;
  logic [IDX_W-1:0]  idx;

  logic [LANES32-1:0] inAct32, regAct32;
  logic [LANES64-1:0] inAct64, regAct64;
  logic [31:0]        lane32 [LANES32];
  logic [63:0]        lane64 [LANES64];

  // predicate sampling per lane width
  for (genvar i = 0; i < LANES32; i++) begin : g_l32
    assign inAct32[i] = predMask[4*i];
    assign regAct32[i] = maskReg[4*i];
    assign lane32[i]   = baseReg[32*i +: 32];
  end
  for (genvar j = 0; j < LANES64; j++) begin : g_l64
    assign inAct64[j] = predMask[8*j];
    assign regAct64[j] = maskReg[8*j];
    assign lane64[j]   = baseReg[64*j +: 64];
  end

  assign anyActive = elemSel64 ? |inAct64 : |inAct32;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      is64Reg <= 1'b0;
      offReg  <= '0;
      hintReg <= '0;
      idx     <= '0;
    end else if (strobe.load) begin
      maskReg <= predMask;
      is64Reg <= elemSel64;
      offReg  <= {imm5, 3'b000};
      hintReg <= hintOp;
      idx     <= '0;
    end else if (strobe.step) begin
      idx <= idx + IDX_W'(1);
    end
  end

  // base vector is only sampled when some lane will use it
  always_ff @(posedge clk) begin
    if (!rstN) baseReg <= '0;
    else if (strobe.load && anyActive) baseReg <= baseVec;
  end

  logic [63:0] laneBase;
  always_comb begin
    if (is64Reg) begin
      laneBase   = lane64[idx[IDX64_W-1:0]];
      laneActive = regAct64[idx[IDX64_W-1:0]];
      lastLane   = (idx == IDX_W'(LANES64 - 1));
    end else begin
      laneBase   = {32'b0, lane32[idx]};
      laneActive = regAct32[idx];
      lastLane   = (idx == IDX_W'(LANES32 - 1));
    end
  end

  assign reqAddr   = laneBase + {56'b0, offReg};
  assign reqWrite  = hintReg[3];
  assign reqLevel  = hintReg[2:1];
  assign reqStream = hintReg[0];
endmodule

// File: rtl/gather_prefetch_seq.sv
module gather_prefetch_seq
  import gps_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              elemSel64,
  input  logic [VLEN-1:0]   baseVec,
  input  logic [VLEN/8-1:0] predMask,
  input  logic [4:0]        imm5,
  input  logic [3:0]        hintOp,
  output logic              busy,
  output logic              done,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [63:0]       reqAddr,
  output logic              reqWrite,
  output logic [1:0]        reqLevel,
  output logic              reqStream
);
  gpsStrobe_t strobe;
  logic anyActive, laneActive, lastLane;

  gps_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .anyActive(anyActive),
    .laneActive(laneActive), .lastLane(lastLane), .reqReady(reqReady),
    .strobe(strobe), .busy(busy), .done(done), .reqValid(reqValid)
  );

  gps_dp #(.VLEN(VLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .elemSel64(elemSel64),
    .baseVec(baseVec), .predMask(predMask), .imm5(imm5), .hintOp(hintOp),
    .anyActive(anyActive), .laneActive(laneActive), .lastLane(lastLane),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqLevel(reqLevel),
    .reqStream(reqStream)
  );
endmodule

// File: rtl/gps_checks.sv
module gps_checks (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        reqValid,
  input logic        reqReady,
  input logic [63:0] reqAddr,
  input logic        reqWrite,
  input logic [1:0]  reqLevel,
  input logic        reqStream
);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqWrite)
                              && $stable(reqLevel) && $stable(reqStream));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  p_done_in_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_valid_in_op_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> busy && !done);

  p_stay_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);
endmodule

bind gather_prefetch_seq gps_checks u_gps_checks (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .reqValid(reqValid),
  .reqReady(reqReady), .reqAddr(reqAddr), .reqWrite(reqWrite),
  .reqLevel(reqLevel), .reqStream(reqStream)
);

// File: tb/tb_gather_prefetch_seq.sv
module tb_gather_prefetch_seq;
  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic elemSel64 = 1'b0;
  logic [VLEN-1:0] baseVec = '0;
  logic [PW-1:0] predMask = '0;
  logic [4:0] imm5 = '0;
  logic [3:0] hintOp = '0;
  logic reqReady = 1'b1;
  logic busy, done, reqValid, reqWrite, reqStream;
  logic [1:0] reqLevel;
  logic [63:0] reqAddr;

  int total = 0;
  int bad = 0;
  bit stallOn = 1'b0;
  logic [67:0] expQ[$];

  gather_prefetch_seq #(.VLEN(VLEN)) dut (
    .clk(clk), .rstN(rstN), .start(start), .elemSel64(elemSel64),
    .baseVec(baseVec), .predMask(predMask), .imm5(imm5), .hintOp(hintOp),
    .busy(busy), .done(done), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqLevel(reqLevel),
    .reqStream(reqStream)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [67:0] act,
                       input logic [67:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk);
    #1 reqReady = stallOn ? ($urandom % 3 != 0) : 1'b1;
  end

  // monitor: scoreboard compare and stall stability
  logic [67:0] prevItem;
  bit prevStall = 1'b0;
  always @(negedge clk) begin
    logic [67:0] got;
    got = {reqWrite, reqLevel, reqStream, reqAddr};
    if (rstN) begin
      if (prevStall) check(reqValid && got == prevItem, "R7", got, prevItem);
      if (reqValid && reqReady) begin
        if (expQ.size() == 0) check(1'b0, "R5 unexpected request", got, '0);
        else begin
          logic [67:0] e;
          e = expQ.pop_front();
          check(got == e, "R2/R3/R4/R6/R11 request", got, e);
        end
      end
      prevStall = reqValid && !reqReady;
      prevItem  = got;
    end
  end

  task automatic runOp(input bit sel64, input logic [VLEN-1:0] base,
                       input logic [PW-1:0] pred, input logic [4:0] imm,
                       input logic [3:0] hint, input bit pokeMid, input bit pokeDone);
    int lanes;
    int waitCnt;
    lanes = sel64 ? VLEN / 64 : VLEN / 32;
    for (int e = 0; e < lanes; e++) begin
      logic [63:0] lane;
      bit act;
      lane = sel64 ? base[64*e +: 64] : {32'b0, base[32*e +: 32]};
      act  = sel64 ? pred[8*e] : pred[4*e];
      if (act) expQ.push_back({hint[3], hint[2:1], hint[0], lane + 64'(imm) * 64'd8});
    end
    @(negedge clk);
    start = 1'b1; elemSel64 = sel64; baseVec = base; predMask = pred;
    imm5 = imm; hintOp = hint;
    @(posedge clk);
    #1 start = 1'b0;
    // change operands after capture: must have no effect (R10)
    baseVec = ~base; predMask = '1; imm5 = ~imm; hintOp = ~hint; elemSel64 = ~sel64;
    @(negedge clk);
    check(busy == 1'b1, "R8 busy after start", 68'(busy), 68'd1);
    if (pokeMid && !done) begin
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
    end
    waitCnt = 0;
    while (!done && waitCnt < 500) begin
      @(negedge clk);
      waitCnt++;
    end
    check(done && busy, "R8 done pulse within busy", 68'({done, busy}), 68'd3);
    if (pokeDone) start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    @(negedge clk);
    check(!done && !busy, "R8/R10 idle after done", 68'({done, busy}), 68'd0);
    repeat (3) @(negedge clk);
    check(!reqValid && !busy, "R10 no new op", 68'({reqValid, busy}), 68'd0);
    check(expQ.size() == 0, "R5/R9 all expected requests seen",
          68'(expQ.size()), 68'd0);
    expQ.delete();
  endtask

  initial begin
    int cyc = 0;
    fork
      begin
        while (cyc < 100000) begin @(posedge clk); cyc++; end
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
  end

  initial begin
    logic [VLEN-1:0] b;
    repeat (3) @(posedge clk);
    #1;
    check(!busy && !done && !reqValid, "R1 reset state",
          68'({busy, done, reqValid}), 68'd0);
    rstN = 1'b1;
    for (int i = 0; i < VLEN / 32; i++) b[32*i +: 32] = 32'h1000_0000 + 32'(i) * 32'h40;
    // R3 all lanes active, 32-bit, read hint
    runOp(1'b0, b, '1, 5'd0, 4'b0000, 1'b0, 1'b0);
    // R3/R5 sparse: stride bits plus ignored odd bits
    runOp(1'b0, b, 32'h0000_1E01 | 32'h2222_2222, 5'd3, 4'b1011, 1'b0, 1'b0);
    // R4 64-bit lanes, pred[4] must be ignored
    for (int i = 0; i < VLEN / 64; i++) b[64*i +: 64] = 64'hABCD_0000_0000_0000 + 64'(i) * 64'h1000;
    runOp(1'b1, b, 32'h0100_0111, 5'd1, 4'b0110, 1'b0, 1'b0);
    // R11 wrap in 64-bit lane
    b[63:0] = 64'hFFFF_FFFF_FFFF_FFF0;
    runOp(1'b1, b, 32'h0000_0001, 5'd31, 4'b1101, 1'b0, 1'b0);
    // R2 32-bit lane zero-extension, max offset
    b = '0; b[32 +: 32] = 32'hFFFF_FFFF; b[224 +: 32] = 32'h8000_0000;
    runOp(1'b0, b, 32'h1000_0010, 5'd31, 4'b0011, 1'b0, 1'b0);
    // R9 no active lane in either width
    runOp(1'b0, b, 32'hEEEE_EEEE, 5'd4, 4'b1111, 1'b0, 1'b0);
    runOp(1'b1, b, 32'hFEFE_FEFE, 5'd4, 4'b1111, 1'b0, 1'b0);
    // R7 back-pressure, R10 start mid-op and during done
    stallOn = 1'b1;
    for (int i = 0; i < VLEN / 32; i++) b[32*i +: 32] = 32'($urandom);
    runOp(1'b0, b, '1, 5'd7, 4'b1001, 1'b1, 1'b1);
    runOp(1'b1, b, 32'h0101_0101, 5'd12, 4'b0100, 1'b1, 1'b1);
    runOp(1'b0, b, 32'h0F0F_F0F0, 5'd20, 4'b1110, 1'b0, 1'b1);
    stallOn = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule